// File: doc/BRIEF.md
# Sticky Error Status Register

This block gathers fault events reported by cache, system-bus and interface checkers into one 64-bit status word. Each fault class has its own sticky bit. A bit is set by an accepted event and stays set until software writes a 1 to it. Reading the word never changes it. Two extra bits sit beside the sticky field. One flags a repeated serious fault. The other records the privilege level of the most recently logged event.

Events arrive on a valid/ready channel as a one-hot class vector, with sideband fields: an ECC marker, a 2-bit 16-byte subunit index, a transaction-start strobe and the privilege level. The block never applies back-pressure: `evt_ready` is high whenever reset is released. An event counts only in a cycle where both `evt_valid` and `evt_ready` are high. Within one 64-byte bus transaction, ECC reports are logged only for the first subunit that faults. The register drives an external error pin for protocol and internal faults. It also requests a disrupting trap when interrupts are enabled and a trap-class bit is set.

Top module: `fault_status_reg`

## Requirements
- R1: After reset, `rd_data` is zero, `err_pin` and `trap_req` are low and `evt_ready` is high.
- R2: An accepted event of class k (one-hot bit k of `evt_class`, k in 0..18) sets `rd_data[33+k]` from the next cycle on. The bit stays set with no write, and reading never clears it.
- R3: A cycle with `sw_wr_en` high clears every bit in 53:33 whose `sw_wdata` bit is 1. Bits written with 0 keep their value. Bit 52 is cleared the same way. All other bits read as zero and ignore writes.
- R4: If an event sets a sticky bit in the same cycle that software clears it, the bit ends up set.
- R5: Bit 53 is set when an accepted event of an uncorrectable or software-correctable class arrives while that class's bit is already set and is not being cleared in the same cycle.
- R6: The hardware-corrected classes are 0, 3, 5, 7, 13 and 15. A repeat of one of these classes never sets bit 53.
- R7: Every logged event loads bit 52 with `evt_priv`. With no logged event, bit 52 holds its value unless it is cleared per R3.
- R8: `txn_start` opens a new transaction. The first ECC event (`evt_ecc` high) in the transaction is logged and its `evt_sub` is recorded. Later ECC events in the same transaction with a different `evt_sub` are dropped: they set no bit and do not change bit 53 or bit 52. ECC events with the same `evt_sub` as the recorded one are logged.
- R9: Events with `evt_ecc` low are never filtered, whatever the transaction state.
- R10: `err_pin` is high exactly while bit 51 (class 18) or bit 50 (class 17) is set.
- R11: `trap_req` is high exactly when `int_en` is high and any of bits 49:33 (classes 0..16) is set.
- R12: An event vector presented with `evt_valid` low has no effect on any bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Fault event present |
| evt_ready | output | 1 | Event accepted (high out of reset) |
| evt_class | input | 19 | One-hot fault class |
| evt_ecc | input | 1 | Event is an ECC report subject to subunit filtering |
| evt_sub | input | 2 | 16-byte subunit index inside the 64-byte transaction |
| txn_start | input | 1 | First beat of a new bus transaction |
| evt_priv | input | 1 | Privilege level at detection |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wdata | input | 64 | Write-1-to-clear data |
| rd_data | output | 64 | Status word |
| int_en | input | 1 | Interrupt enable |
| err_pin | output | 1 | External error pin |
| trap_req | output | 1 | Disrupting-trap request |

## Verification
Every cycle, the assertions check the per-bit set, clear and hold rules, and that a set wins over a clear in the same cycle. They also check that a dropped ECC event leaves the word unchanged, that a new multiple-error flag is always traced back to an eligible class, and that the error pin only falls after a software write. The bench scenarios are needed for the rest. They show how the subunit filter behaves across transaction boundaries, that the multiple-error flag ignores repeated hardware-corrected classes, that the privilege bit is overwritten on each logged event, and that the trap request is gated by the enable.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int REG_W       = 64;
  localparam int N_CLASS     = 19;
  localparam int STICKY_LSB  = 33;
  localparam int PRIV_POS    = STICKY_LSB + N_CLASS;
  localparam int MULTI_POS   = PRIV_POS + 1;
  localparam logic [N_CLASS-1:0] HW_CORR_MASK = 19'h0A0A9;
  localparam logic [N_CLASS-1:0] TRAP_MASK    = 19'h1FFFF;
  localparam logic [N_CLASS-1:0] PIN_MASK     = 19'h60000;
endpackage

// File: rtl/fsr_sub_filter.sv
module fsr_sub_filter #(
  parameter int SUB_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_fire_i,
  input  logic             evt_ecc_i,
  input  logic [SUB_W-1:0] sub_i,
  input  logic             txn_start_i,
  output logic             pass_o
);
  logic             have_q;
  logic [SUB_W-1:0] first_q;
  logic             have_eff;

  // A start strobe discards the previous transaction's record in the same cycle
  assign have_eff = have_q & ~txn_start_i;
  assign pass_o   = ~evt_ecc_i | ~have_eff | (sub_i == first_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q  <= 1'b0;
      first_q <= '0;
    end else if (evt_fire_i && evt_ecc_i && !have_eff) begin
      have_q  <= 1'b1;
      first_q <= sub_i;
    end else if (txn_start_i) begin
      have_q  <= 1'b0;
    end
  end

  AST_FIRST_RECORDED: assert property (@(posedge clk) disable iff (!rst_n) (evt_fire_i && evt_ecc_i && !have_eff) |=> (have_q && first_q == $past(sub_i))); // R8
endmodule

// File: rtl/fsr_sticky_bank.sv
module fsr_sticky_bank #(
  parameter int                 N       = 19,
  parameter logic [N-1:0]       HW_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o,
  output logic         repeat_o
);
  logic [N-1:0] rep_bits;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q_o[g] <= 1'b0;
      else if (set_i[g])   q_o[g] <= 1'b1;
      else if (clr_i[g])   q_o[g] <= 1'b0;
    end
    // repeat of a serious class whose bit survives this cycle
    assign rep_bits[g] = set_i[g] & q_o[g] & ~clr_i[g] & ~HW_MASK[g];

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) set_i[g] |=> q_o[g]); // R4
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n) (clr_i[g] && !set_i[g]) |=> !q_o[g]); // R3
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!clr_i[g] && !set_i[g]) |=> (q_o[g] == $past(q_o[g]))); // R2
  end

  assign repeat_o = |rep_bits;
endmodule

// File: rtl/fsr_alarm.sv
module fsr_alarm #(
  parameter int           N         = 19,
  parameter logic [N-1:0] PIN_MASK  = '0,
  parameter logic [N-1:0] TRAP_MASK = '0
) (
  input  logic [N-1:0] st_i,
  input  logic         int_en_i,
  output logic         err_pin_o,
  output logic         trap_o
);
  assign err_pin_o = |(st_i & PIN_MASK);
  assign trap_o    = int_en_i & |(st_i & TRAP_MASK);
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
  import fsr_pkg::*;
#(
  parameter int                     NUM_CLASS = N_CLASS,
  parameter int                     SUB_W     = 2,
  parameter logic [NUM_CLASS-1:0]   HW_MASK   = HW_CORR_MASK,
  parameter logic [NUM_CLASS-1:0]   TRAPS     = TRAP_MASK,
  parameter logic [NUM_CLASS-1:0]   PINS      = PIN_MASK
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_valid,
  output logic                 evt_ready,
  input  logic [NUM_CLASS-1:0] evt_class,
  input  logic                 evt_ecc,
  input  logic [SUB_W-1:0]     evt_sub,
  input  logic                 txn_start,
  input  logic                 evt_priv,
  input  logic                 sw_wr_en,
  input  logic [REG_W-1:0]     sw_wdata,
  output logic [REG_W-1:0]     rd_data,
  input  logic                 int_en,
  output logic                 err_pin,
  output logic                 trap_req
);
  localparam int ST_LO = STICKY_LSB;
  localparam int ST_HI = STICKY_LSB + NUM_CLASS - 1;
  localparam int PR_B  = ST_HI + 1;
  localparam int ME_B  = ST_HI + 2;

  logic                 fire, pass, logged, repeat_hit;
  logic [NUM_CLASS-1:0] set_vec, clr_vec, st_q;
  logic                 me_q, priv_q;
  logic                 unused_wdata;

  assign evt_ready = rst_n;
  assign fire      = evt_valid & evt_ready;
  assign logged    = fire & pass & (|evt_class);
  assign set_vec   = logged ? evt_class : '0;
  assign clr_vec   = sw_wr_en ? sw_wdata[ST_HI:ST_LO] : '0;
  assign unused_wdata = ^{sw_wdata[REG_W-1:ME_B+1], sw_wdata[ST_LO-1:0]};

  fsr_sub_filter #(.SUB_W(SUB_W)) u_filter (
    .clk(clk), .rst_n(rst_n), .evt_fire_i(fire), .evt_ecc_i(evt_ecc),
    .sub_i(evt_sub), .txn_start_i(txn_start), .pass_o(pass)
  );

  fsr_sticky_bank #(.N(NUM_CLASS), .HW_MASK(HW_MASK)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec),
    .q_o(st_q), .repeat_o(repeat_hit)
  );

  fsr_alarm #(.N(NUM_CLASS), .PIN_MASK(PINS), .TRAP_MASK(TRAPS)) u_alarm (
    .st_i(st_q), .int_en_i(int_en), .err_pin_o(err_pin), .trap_o(trap_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      me_q   <= 1'b0;
      priv_q <= 1'b0;
    end else begin
      if (repeat_hit)                  me_q <= 1'b1;
      else if (sw_wr_en && sw_wdata[ME_B]) me_q <= 1'b0;
      if (logged)                      priv_q <= evt_priv;
      else if (sw_wr_en && sw_wdata[PR_B]) priv_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data              = '0;
    rd_data[ST_HI:ST_LO] = st_q;
    rd_data[PR_B]        = priv_q;
    rd_data[ME_B]        = me_q;
  end

  AST_ONEHOT_IN: assert property (@(posedge clk) disable iff (!rst_n) evt_valid |-> $onehot0(evt_class)); // R2
  AST_DROP_NO_LOG: assert property (@(posedge clk) disable iff (!rst_n) (fire && !pass && !sw_wr_en) |=> $stable(rd_data)); // R8
  AST_PLAIN_LOGGED: assert property (@(posedge clk) disable iff (!rst_n) (fire && !evt_ecc && (|evt_class)) |=> (|(st_q & $past(evt_class)))); // R9
  AST_ME_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) $rose(me_q) |-> $past(fire && (|(evt_class & ~HW_MASK)))); // R6
  AST_PIN_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(err_pin) |-> $past(sw_wr_en)); // R10
  AST_TRAP_GATE: assert property (@(posedge clk) disable iff (!rst_n) !int_en |-> !trap_req); // R11
  AST_IDLE_NOEFFECT: assert property (@(posedge clk) disable iff (!rst_n) (!evt_valid && !sw_wr_en) |=> $stable(rd_data)); // R12
endmodule

// File: tb/fault_status_reg_tb.sv
module fault_status_reg_tb;
  localparam logic [18:0] HW   = 19'h0A0A9;
  localparam logic [18:0] TRAP = 19'h1FFFF;
  localparam logic [18:0] PIN  = 19'h60000;

  logic clk = 0, rst_n = 0;
  logic evt_valid = 0, evt_ecc = 0, txn_start = 0, evt_priv = 0;
  logic [18:0] evt_class = '0;
  logic [1:0]  evt_sub = '0;
  logic sw_wr_en = 0, int_en = 0;
  logic [63:0] sw_wdata = '0;
  logic evt_ready, err_pin, trap_req;
  logic [63:0] rd_data;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [18:0] m_st = '0;
  logic m_me = 0, m_priv = 0, m_have = 0;
  logic [1:0] m_first = '0;

  always #4 clk = ~clk;

  fault_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_class(evt_class), .evt_ecc(evt_ecc), .evt_sub(evt_sub),
    .txn_start(txn_start), .evt_priv(evt_priv), .sw_wr_en(sw_wr_en),
    .sw_wdata(sw_wdata), .rd_data(rd_data), .int_en(int_en),
    .err_pin(err_pin), .trap_req(trap_req)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [63:0] w;
    w = '0;
    w[51:33] = m_st; w[52] = m_priv; w[53] = m_me;
    check("R2 sticky field", {45'd0, rd_data[51:33]}, {45'd0, m_st});
    check("R5 multi flag", {63'd0, rd_data[53]}, {63'd0, m_me});
    check("R7 priv bit", {63'd0, rd_data[52]}, {63'd0, m_priv});
    check("R3 whole word", rd_data, w);
    check("R10 err pin", {63'd0, err_pin}, {63'd0, |(m_st & PIN)});
    check("R11 trap", {63'd0, trap_req}, {63'd0, int_en & |(m_st & TRAP)});
    check("R12 ready", {63'd0, evt_ready}, 64'd1);
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic cyc(input logic v, input int k, input logic ecc, input logic [1:0] sub,
                     input logic ts, input logic pr, input logic we, input logic [63:0] wd);
    logic [18:0] cls, clr, n_st;
    logic hv, pass, logged, hit, n_me, n_priv;
    cls = (k >= 0) ? (19'd1 << k) : '0;
    evt_valid = v; evt_class = cls; evt_ecc = ecc; evt_sub = sub;
    txn_start = ts; evt_priv = pr; sw_wr_en = we; sw_wdata = wd;
    hv = m_have && !ts;
    pass = !ecc || !hv || (sub == m_first);
    logged = v && pass && (cls != 0);
    clr = we ? wd[51:33] : '0;
    hit = 0;
    for (int i = 0; i < 19; i++)
      if (logged && cls[i] && m_st[i] && !clr[i] && !HW[i]) hit = 1;
    n_st = (m_st & ~clr) | (logged ? cls : 19'd0);
    n_me = hit ? 1'b1 : (we && wd[53]) ? 1'b0 : m_me;
    n_priv = logged ? pr : (we && wd[52]) ? 1'b0 : m_priv;
    @(posedge clk);
    #1;
    m_st = n_st; m_me = n_me; m_priv = n_priv;
    if (v && ecc && !hv) begin m_have = 1; m_first = sub; end
    else if (ts) m_have = 0;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(); cyc(0, -1, 0, 0, 0, 0, 0, '0); endtask
  task automatic ev(input int k, input logic pr); cyc(1, k, 0, 0, 0, pr, 0, '0); endtask
  task automatic ecc_ev(input int k, input logic [1:0] s, input logic ts); cyc(1, k, 1, s, ts, 0, 0, '0); endtask
  task automatic wr(input logic [63:0] d); cyc(0, -1, 0, 0, 0, 0, 1, d); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", rd_data, '0);
    check("R1 reset pin", {63'd0, err_pin}, 64'd0);
    check("R1 reset trap", {63'd0, trap_req}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 ready after reset", {63'd0, evt_ready}, 64'd1);

    ev(1, 1);                            // uncorrectable class
    check("R2 bit34 set", {63'd0, rd_data[34]}, 64'd1);
    check("R7 priv captured", {63'd0, rd_data[52]}, 64'd1);
    check("R11 trap off while disabled", {63'd0, trap_req}, 64'd0);
    int_en = 1; idle();
    check("R11 trap on", {63'd0, trap_req}, 64'd1);
    repeat (3) idle();
    check("R2 bit34 persists", {63'd0, rd_data[34]}, 64'd1);
    ev(1, 0);
    check("R5 repeat sets multi", {63'd0, rd_data[53]}, 64'd1);
    check("R7 priv overwritten", {63'd0, rd_data[52]}, 64'd0);
    wr(64'd1 << 53);
    check("R3 multi cleared", {63'd0, rd_data[53]}, 64'd0);
    check("R3 bit34 untouched", {63'd0, rd_data[34]}, 64'd1);
    ev(0, 0); ev(0, 0); ev(13, 1); ev(13, 1);
    check("R6 hw repeats no multi", {63'd0, rd_data[53]}, 64'd0);
    ev(9, 0); ev(9, 0);
    check("R5 sw-correctable repeat", {63'd0, rd_data[53]}, 64'd1);
    wr(64'd1 << 53);
    cyc(1, 1, 0, 0, 0, 0, 1, 64'd1 << 34); // set and clear collide
    check("R4 set wins", {63'd0, rd_data[34]}, 64'd1);
    check("R5 no multi when cleared same cycle", {63'd0, rd_data[53]}, 64'd0);
    wr('1);
    check("R3 full clear", rd_data, '0);
    int_en = 1;
    ev(18, 0);
    check("R10 pin on", {63'd0, err_pin}, 64'd1);
    check("R11 pin class not trap", {63'd0, trap_req}, 64'd0);
    ev(17, 0);
    wr(64'd1 << 51);
    check("R10 pin held by bit50", {63'd0, err_pin}, 64'd1);
    wr(64'd1 << 50);
    check("R10 pin off", {63'd0, err_pin}, 64'd0);

    ecc_ev(0, 2'd1, 1);
    check("R8 first ecc logged", {63'd0, rd_data[33]}, 64'd1);
    ecc_ev(1, 2'd2, 0);
    check("R8 later subunit dropped", {63'd0, rd_data[34]}, 64'd0);
    ecc_ev(1, 2'd1, 0);
    check("R8 same subunit logged", {63'd0, rd_data[34]}, 64'd1);
    cyc(1, 4, 0, 2'd3, 0, 1, 0, '0);
    check("R9 plain event passes", {63'd0, rd_data[37]}, 64'd1);
    ecc_ev(4, 2'd0, 0);
    check("R8 dropped no multi", {63'd0, rd_data[53]}, 64'd0);
    check("R8 dropped no priv", {63'd0, rd_data[52]}, 64'd1);
    cyc(0, -1, 0, 0, 1, 0, 0, '0);
    ecc_ev(12, 2'd3, 0);
    check("R8 new txn logs", {63'd0, rd_data[45]}, 64'd1);
    cyc(0, 6, 0, 0, 0, 1, 0, '0);
    check("R12 invalid ignored", {63'd0, rd_data[39]}, 64'd0);
    wr('1);
    idle();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule